// File: doc/BRIEF.md
# Thermal Throttle Clock Modulator

This block slows a processor core when it runs too hot. It drives a clock-enable that the core's clock gate uses. While throttling is off, the enable stays high. While throttling is on, the enable is high for a programmed number of slots in every eight-slot frame, so the core's throughput drops in proportion to the duty setting.

Throttling has three possible causes, and any one of them is enough:
- an on-demand bit in the control register;
- the on-die sensor's "maximum temperature reached" flag, used only when the monitor is enabled;
- an external agent pulling the shared active-low hot line low, also used only when the monitor is enabled.

When throttling is caused by the sensor, the block pulls its own hot output low.

The block has two further outputs. The first is a captured digital temperature reading, marked valid only while the core is in its active power state. The second is a catastrophic trip flag. This flag is sticky and does not depend on throttling.

Top module: `thermal_throttle`

## Requirements
- R1: After reset, the control register reads 0, `clkEn` is 1, `throttleActive` is 0, `hotOutN` is 1, `tripOut` is 0 and `tempValid` is 0.
- R2: A write with `regWe` high stores `regWdata` into the control register at that clock edge. `ctrlRd` returns the stored value from the next cycle on. The register fields are: bit 0 = monitor enable, bits 3:1 = duty field, bit 4 = on-demand.
- R3: With bit 4 set, `throttleActive` goes high one clock after the register update. This happens whatever the values of `tempHot`, `hotLineIn` and bit 0.
- R4: While throttling is active, count the cycles since activation as i = 0, 1, 2, and so on. `clkEn` is 1 exactly when (i mod 8) < N, where N is the duty field value for values 1 to 7.
- R5: A duty field of 0 behaves as N = 4, giving half the slots.
- R6: With bit 0 set, `tempHot` high activates throttling one cycle later. With bit 0 clear, `tempHot` has no effect.
- R7: With bit 0 set, `hotLineIn` low activates throttling one cycle later and leaves `hotOutN` high. With bit 0 clear, `hotLineIn` has no effect.
- R8: `hotOutN` is 0 exactly in the cycle after a cycle in which bit 0 and `tempHot` were both 1.
- R9: `tempValid` equals `coreActive` delayed by one cycle. `tempReading` captures `tempCode` only when `coreActive` is 1, and holds its value otherwise.
- R10: `tripOut` sets one cycle after `tripIn` is high. It then stays set until reset, and it has no effect on throttling.
- R11: When throttling is inactive, `clkEn` is 1. Every new activation restarts the pattern at slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWe | input | 1 | Control register write strobe |
| regWdata | input | 5 | Control register write data |
| ctrlRd | output | 5 | Control register contents |
| tempHot | input | 1 | Sensor flag: maximum temperature reached |
| hotLineIn | input | 1 | Sampled level of shared hot line, active low |
| tripIn | input | 1 | Sensor flag: catastrophic temperature |
| coreActive | input | 1 | Core is in its active power state |
| tempCode | input | 7 | Raw digital temperature from sensor |
| clkEn | output | 1 | Core clock enable, gated by duty pattern |
| throttleActive | output | 1 | Throttling in effect |
| hotOutN | output | 1 | Hot line drive, active low |
| tripOut | output | 1 | Sticky catastrophic trip flag |
| tempValid | output | 1 | Temperature reading valid |
| tempReading | output | 7 | Captured temperature reading |

## Verification
The hardest part to reach from the ports is the phase of the eight-slot pattern, together with the point where it restarts. The counter is only visible through `clkEn`, so the bench steps the duty field through all eight codes. For each code it activates throttling through the on-demand bit, then compares two full frames slot by slot against the arithmetic pattern. After that it deactivates and reactivates to confirm that slot 0 comes first. The bench also drives the sensor-based and external hot sources with the monitor bit both set and clear, and checks that only the sensor source pulls the hot output low.

// File: rtl/thr_pkg.sv
package thr_pkg;
  localparam int SLOT_BITS = 3;
  localparam int TEMP_W    = 7;

  typedef struct packed {
    logic gateOn;
    logic tempCapture;
  } thr_strobe_t;
endpackage

// File: rtl/thr_ctrl.sv
module thr_ctrl
  import thr_pkg::*;
#(
  parameter int SLOTW = SLOT_BITS,
  localparam int FIELD_W = SLOTW + 2,
  localparam int ONDEM_BIT = SLOTW + 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWe,
  input  logic [FIELD_W-1:0] regWdata,
  input  logic               tempHot,
  input  logic               hotLineIn,
  input  logic               tripIn,
  input  logic               coreActive,
  output logic [FIELD_W-1:0] ctrlRd,
  output logic [SLOTW-1:0]   dutyField,
  output thr_strobe_t        strobe,
  output logic               throttleActive,
  output logic               hotOutN,
  output logic               tripOut,
  output logic               tempValid
);
  logic [FIELD_W-1:0] ctrlQ;
  logic activeQ, autoHotQ, tripQ, validQ;
  logic monEn, onDem, autoHot, extHot;

  assign monEn     = ctrlQ[0];
  assign onDem     = ctrlQ[ONDEM_BIT];
  assign dutyField = ctrlQ[SLOTW:1];
  assign autoHot   = monEn & tempHot;
  assign extHot    = monEn & ~hotLineIn;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlQ    <= '0;
      activeQ  <= 1'b0;
      autoHotQ <= 1'b0;
      tripQ    <= 1'b0;
      validQ   <= 1'b0;
    end else begin
      if (regWe) ctrlQ <= regWdata;
      activeQ  <= onDem | autoHot | extHot;
      autoHotQ <= autoHot;
      tripQ    <= tripQ | tripIn;
      validQ   <= coreActive;
    end
  end

  assign ctrlRd             = ctrlQ;
  assign throttleActive     = activeQ;
  assign hotOutN            = ~autoHotQ;
  assign tripOut            = tripQ;
  assign tempValid          = validQ;
  assign strobe.gateOn      = activeQ;
  assign strobe.tempCapture = coreActive;

  // R10: trip is sticky
  p_trip_sticky_r10: assert property (@(posedge clk) disable iff (!rstN)
    tripOut |=> tripOut);
  // R3: on-demand forces throttling
  p_ondemand_r3: assert property (@(posedge clk) disable iff (!rstN)
    onDem |=> throttleActive);
  // R8: hot drive implies throttling
  p_hot_active_r8: assert property (@(posedge clk) disable iff (!rstN)
    !hotOutN |-> throttleActive);
  // R6: with monitor and on-demand off, nothing throttles
  p_no_src_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!monEn && !onDem) |=> !throttleActive);
  // R9: valid follows core state
  p_valid_r9: assert property (@(posedge clk) disable iff (!rstN)
    coreActive |=> tempValid);
endmodule

// File: rtl/thr_gate.sv
module thr_gate
  import thr_pkg::*;
#(
  parameter int SLOTW = SLOT_BITS,
  parameter int TW    = TEMP_W,
  localparam logic [SLOTW-1:0] HALF = SLOTW'(1 << (SLOTW - 1))
) (
  input  logic             clk,
  input  logic             rstN,
  input  thr_strobe_t      strobe,
  input  logic [SLOTW-1:0] dutyField,
  input  logic [TW-1:0]    tempCode,
  output logic             clkEn,
  output logic [TW-1:0]    tempReading
);
  logic [SLOTW-1:0] slotCnt;
  logic [SLOTW-1:0] slotsOn;
  logic [TW-1:0]    readingQ;

  assign slotsOn = (dutyField == '0) ? HALF : dutyField;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      slotCnt  <= '0;
      readingQ <= '0;
    end else begin
      if (strobe.gateOn) slotCnt <= slotCnt + SLOTW'(1);
      else               slotCnt <= '0;
      if (strobe.tempCapture) readingQ <= tempCode;
    end
  end

  assign clkEn       = !strobe.gateOn || (slotCnt < slotsOn);
  assign tempReading = readingQ;

  // R4: first slot of each frame always enabled
  p_slot0_on_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.gateOn && slotCnt == '0) |-> clkEn);
  // R11: enable only drops while throttling
  p_gate_low_r11: assert property (@(posedge clk) disable iff (!rstN)
    !clkEn |-> strobe.gateOn);
  // R9: reading held when core not active
  p_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    !$past(strobe.tempCapture) |-> $stable(tempReading));
endmodule

// File: rtl/thermal_throttle.sv
module thermal_throttle
  import thr_pkg::*;
#(
  parameter int SLOTW = SLOT_BITS,
  parameter int TW    = TEMP_W,
  localparam int FIELD_W = SLOTW + 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWe,
  input  logic [FIELD_W-1:0] regWdata,
  output logic [FIELD_W-1:0] ctrlRd,
  input  logic               tempHot,
  input  logic               hotLineIn,
  input  logic               tripIn,
  input  logic               coreActive,
  input  logic [TW-1:0]      tempCode,
  output logic               clkEn,
  output logic               throttleActive,
  output logic               hotOutN,
  output logic               tripOut,
  output logic               tempValid,
  output logic [TW-1:0]      tempReading
);
  thr_strobe_t      strobe;
  logic [SLOTW-1:0] dutyField;

  thr_ctrl #(.SLOTW(SLOTW)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regWdata(regWdata),
    .tempHot(tempHot), .hotLineIn(hotLineIn), .tripIn(tripIn),
    .coreActive(coreActive), .ctrlRd(ctrlRd), .dutyField(dutyField),
    .strobe(strobe), .throttleActive(throttleActive), .hotOutN(hotOutN),
    .tripOut(tripOut), .tempValid(tempValid)
  );

  thr_gate #(.SLOTW(SLOTW), .TW(TW)) u_gate (
    .clk(clk), .rstN(rstN), .strobe(strobe), .dutyField(dutyField),
    .tempCode(tempCode), .clkEn(clkEn), .tempReading(tempReading)
  );
endmodule

// File: tb/thermal_throttle_tb.sv
module thermal_throttle_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWe = 1'b0;
  logic [4:0] regWdata = '0;
  logic [4:0] ctrlRd;
  logic tempHot = 1'b0, hotLineIn = 1'b1, tripIn = 1'b0, coreActive = 1'b0;
  logic [6:0] tempCode = '0;
  logic clkEn, throttleActive, hotOutN, tripOut, tempValid;
  logic [6:0] tempReading;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  thermal_throttle u_dut (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regWdata(regWdata),
    .ctrlRd(ctrlRd), .tempHot(tempHot), .hotLineIn(hotLineIn),
    .tripIn(tripIn), .coreActive(coreActive), .tempCode(tempCode),
    .clkEn(clkEn), .throttleActive(throttleActive), .hotOutN(hotOutN),
    .tripOut(tripOut), .tempValid(tempValid), .tempReading(tempReading)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] d);
    @(negedge clk); regWe = 1'b1; regWdata = d;
    @(negedge clk); regWe = 1'b0;
  endtask

  task automatic resetIdle(input string tag);
    check({tag, " ctrl"}, ctrlRd, 0);
    check({tag, " clkEn"}, clkEn, 1);
    check({tag, " active"}, throttleActive, 0);
    check({tag, " hotOutN"}, hotOutN, 1);
    check({tag, " trip"}, tripOut, 0);
    check({tag, " valid"}, tempValid, 0);
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk); cyc++;
      if (cyc > 100000) begin
        errors++; checks++;
        $display("FAIL watchdog: actual %0d expected <100000", cyc);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    resetIdle("R1");
    rstN = 1'b1;

    // Duty sweep through on-demand (R2, R3, R4, R5, R11)
    for (int d = 0; d < 8; d++) begin
      int n;
      logic [4:0] v;
      n = (d == 0) ? 4 : d;
      v = {1'b1, 3'(d), 1'b0};
      wr(v);
      check("R2 readback", ctrlRd, v);
      check("R3 not yet", throttleActive, 0);
      for (int i = 0; i < 16; i++) begin
        @(negedge clk);
        check("R3 active", throttleActive, 1);
        check((d == 0) ? "R5 duty0 pattern" : "R4 pattern", clkEn, ((i % 8) < n) ? 1 : 0);
      end
      wr(5'h00);
      @(negedge clk);
      check("R11 idle active", throttleActive, 0);
      check("R11 idle clkEn", clkEn, 1);
    end

    // Restart at slot 0 (R11)
    wr(5'h12);
    repeat (3) @(negedge clk);
    wr(5'h00);
    @(negedge clk);
    wr(5'h12);
    @(negedge clk); check("R11 restart slot0", clkEn, 1);
    @(negedge clk); check("R11 restart slot1", clkEn, 0);
    wr(5'h00);
    @(negedge clk);

    // Automatic mode (R6, R8)
    wr(5'h05);
    tempHot = 1'b1;
    @(negedge clk);
    check("R6 auto active", throttleActive, 1);
    check("R8 hot low", hotOutN, 0);
    check("R4 auto slot0", clkEn, 1);
    @(negedge clk); check("R4 auto slot1", clkEn, 1);
    @(negedge clk); check("R4 auto slot2", clkEn, 0);
    tempHot = 1'b0;
    @(negedge clk);
    check("R6 auto release", throttleActive, 0);
    check("R8 hot release", hotOutN, 1);

    // Monitor off: sources ignored (R6, R7)
    wr(5'h04);
    tempHot = 1'b1; hotLineIn = 1'b0;
    @(negedge clk);
    check("R6 ignored", throttleActive, 0);
    check("R7 ignored", clkEn, 1);
    check("R8 ignored", hotOutN, 1);
    tempHot = 1'b0; hotLineIn = 1'b1;

    // External hot line (R7)
    wr(5'h01);
    hotLineIn = 1'b0;
    @(negedge clk);
    check("R7 ext active", throttleActive, 1);
    check("R7 hot not driven", hotOutN, 1);
    hotLineIn = 1'b1;
    @(negedge clk);
    check("R7 ext release", throttleActive, 0);

    // Temperature reading (R9)
    coreActive = 1'b1; tempCode = 7'd85;
    @(negedge clk);
    check("R9 valid", tempValid, 1);
    check("R9 reading", tempReading, 85);
    coreActive = 1'b0; tempCode = 7'd20;
    @(negedge clk);
    check("R9 invalid", tempValid, 0);
    check("R9 held", tempReading, 85);

    // Trip (R10)
    wr(5'h00);
    tripIn = 1'b1;
    @(negedge clk);
    tripIn = 1'b0;
    check("R10 set", tripOut, 1);
    check("R10 no throttle", throttleActive, 0);
    repeat (5) @(negedge clk);
    check("R10 sticky", tripOut, 1);
    rstN = 1'b0;
    @(negedge clk);
    resetIdle("R10 R1 after reset");
    rstN = 1'b1;

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule